// File: doc/BRIEF.md
# Burst System Bus Master

This block runs one transfer at a time on a split-tenure system bus for a secondary cache controller. An upstream agent hands it a request that carries an address, a direction, a burst flag, a cache-inhibit flag, an intent-to-modify flag and a beat-ordering choice. The block arbitrates for the address bus, launches the address phase with a one-clock start strobe, and waits for the address acknowledge. It then waits for a data bus grant that is qualified by an idle data bus. After that it moves one, four or eight double-word beats, each paced by the slave's transfer acknowledge.

Beat addresses follow either critical-word-first order, which starts at the requested double word and wraps within the aligned line, or zero-word-first order. The acknowledge either comes one clock ahead of read data (full speed), so that the RAM address can be advanced early, or it comes in the same clock as the data (half speed). Address-phase outputs are gated by an output enable that stands in for three-state release. A one-clock done pulse closes every transfer.

Top module: `burst_bus_master`

## Requirements
- R1: A burst has 4 beats when `cfg_line64` is 0 and 8 beats when it is 1. The mode is sampled when the request is accepted.
- R2: When `req_cwf` is 1, beat k uses word offset (s + k) mod N, where s is the request address bits [5:3] masked to N-1. When `req_cwf` is 0, beat k uses offset k. `beat_addr` is the request address with the line-offset bits and bits [2:0] cleared, OR'd with the offset shifted left by 3.
- R3: When `req_inhibit` is 1, `req_burst` is ignored and exactly one beat is moved, at the request address with bits [2:0] cleared.
- R4: `bus_req` is held from acceptance until `bus_grant` is sampled high. In the next clock `start_strobe` is high for exactly one clock, `bus_req` is low, and `a_oe`/`abus_busy` are high with `a_addr` equal to the request address.
- R5: `a_oe` and the attributes fall in the clock after `addr_ack` is sampled high.
- R6: `dbus_busy` rises only in the clock after `dbus_grant` is sampled high while `dbus_busy_in` is low.
- R7: `beat_addr` and `beat_word` hold while `xfer_ack` is low. They advance in the clock after a sampled acknowledge.
- R8: On reads, `rd_strobe` and `rd_word` appear one clock after the acknowledge when `cfg_half` is 0, and in the same clock as the acknowledge when `cfg_half` is 1.
- R9: `a_inval` is high during the address phase only for a burst read that is flagged intent-to-modify. It is low for plain fills, writes and inhibited transfers.
- R10: On writes, `d_oe` is high for the whole data tenure and `d_out` equals `wr_data`. The data for the current word stays presented until its acknowledge is sampled.
- R11: `req_done` is high for exactly one clock, the clock after the last acknowledge. In that clock and at reset, `bus_req`, `a_oe` and `dbus_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_line64 | input | 1 | 1: 64-byte line (8 beats), 0: 32-byte line (4 beats) |
| cfg_half | input | 1 | 1: half-speed acknowledge timing |
| req_valid | input | 1 | Request; accepted while idle |
| req_addr | input | ADDR_W | Requested byte address |
| req_write | input | 1 | 1: write transfer |
| req_burst | input | 1 | Burst request |
| req_inhibit | input | 1 | Cache-inhibited; forces one beat |
| req_itm | input | 1 | Intent-to-modify |
| req_cwf | input | 1 | 1: critical-word-first ordering |
| req_done | output | 1 | One-clock completion pulse |
| bus_req | output | 1 | Address bus request |
| bus_grant | input | 1 | Qualified address bus grant |
| start_strobe | output | 1 | Transfer start, one clock |
| abus_busy | output | 1 | Address bus busy |
| addr_ack | input | 1 | Address acknowledge |
| a_oe | output | 1 | Address/attribute output enable |
| a_addr | output | ADDR_W | Address bus value |
| a_write | output | 1 | Direction attribute |
| a_burst | output | 1 | Burst attribute |
| a_inval | output | 1 | Invalidate attribute |
| dbus_grant | input | 1 | Data bus grant |
| dbus_busy_in | input | 1 | Data bus busy from other masters |
| dbus_busy | output | 1 | Data tenure held |
| xfer_ack | input | 1 | Transfer acknowledge |
| beat_addr | output | ADDR_W | Current beat address |
| beat_word | output | $clog2(LONG_BEATS) | Current word offset in line |
| wr_data | input | DATA_W | Write data for `beat_word` |
| d_oe | output | 1 | Write data output enable |
| d_out | output | DATA_W | Write data onto the bus |
| rd_strobe | output | 1 | Read data valid on the bus |
| rd_word | output | $clog2(LONG_BEATS) | Word offset of the read data |

## Verification
Each result is due at a fixed distance from its cause. The start strobe comes one clock after the grant edge, the attribute release one clock after the address acknowledge, and data tenure one clock after a qualified data grant. The done pulse comes one clock after the last acknowledge. Read strobes come one clock after the acknowledge at full speed and in the same clock at half speed. The bench drives inputs just after a rising edge and samples at the following falling edge, so every expected value is read in the exact cycle it is due. A scoreboard queue holds the expected beat addresses and word offsets, and the monitor compares them in every data-tenure cycle, including wait states.

// File: rtl/bm_pkg.sv
package bm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARB,
      ST_ADDR,
      ST_DWAIT,
      ST_DATA,
      ST_DONE
   } bm_state_e;
endpackage

// File: rtl/bm_ctrl.sv
module bm_ctrl
   import bm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      bus_grant,
   input  logic      addr_ack,
   input  logic      dbus_grant,
   input  logic      dbus_busy_in,
   input  logic      xfer_ack,
   input  logic      last_beat,
   output bm_state_e state,
   output logic      accept,
   output logic      start_q,
   output logic      beat_adv,
   output logic      beat_clr
);
   bm_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (req_valid)                    nxt = ST_ARB;
         ST_ARB:   if (bus_grant)                    nxt = ST_ADDR;
         ST_ADDR:  if (addr_ack)                     nxt = ST_DWAIT;
         ST_DWAIT: if (dbus_grant && !dbus_busy_in)  nxt = ST_DATA;
         ST_DATA:  if (xfer_ack && last_beat)        nxt = ST_DONE;
         ST_DONE:                                    nxt = ST_IDLE;
         default:                                    nxt = ST_IDLE;
      endcase
   end

   assign accept   = (state == ST_IDLE) && req_valid;
   assign beat_adv = (state == ST_DATA) && xfer_ack;
   assign beat_clr = (state == ST_DWAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         start_q <= 1'b0;
      end else begin
         state   <= nxt;
         start_q <= (state == ST_ARB) && bus_grant;
      end
   end
endmodule

// File: rtl/bm_beat_gen.sv
module bm_beat_gen #(
   parameter int ADDR_W  = 32,
   parameter int BYTE_LG = 3,
   parameter int WORD_LG = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               adv,
   input  logic [ADDR_W-1:0]  base,
   input  logic [WORD_LG-1:0] mask,
   input  logic               cwf,
   output logic [ADDR_W-1:0]  beat_addr,
   output logic [WORD_LG-1:0] word,
   output logic               last
);
   localparam logic [ADDR_W-1:0] LOW_M = ADDR_W'((64'd1 << BYTE_LG) - 64'd1);

   logic [WORD_LG-1:0] cnt;
   logic [WORD_LG-1:0] start;
   logic [ADDR_W-1:0]  keep_m;

   assign start  = cwf ? (base[BYTE_LG +: WORD_LG] & mask) : '0;
   assign word   = (start + cnt) & mask;
   assign last   = (cnt == mask);
   assign keep_m = ~((ADDR_W'(mask) << BYTE_LG) | LOW_M);
   assign beat_addr = (base & keep_m) | (ADDR_W'(word) << BYTE_LG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (clr)           cnt <= '0;
      else if (adv && !last)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/bm_ack_align.sv
module bm_ack_align #(
   parameter int WORD_LG = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               half,
   input  logic               ack_rd,
   input  logic [WORD_LG-1:0] word,
   output logic               rd_strobe,
   output logic [WORD_LG-1:0] rd_word
);
   logic               cap_q;
   logic [WORD_LG-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= 1'b0;
         word_q <= '0;
      end else begin
         cap_q  <= ack_rd && !half;
         word_q <= word;
      end
   end

   assign rd_strobe = half ? ack_rd : cap_q;
   assign rd_word   = half ? word   : word_q;
endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master
   import bm_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 64,
   parameter int SHORT_BEATS = 4,
   parameter int LONG_BEATS  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_line64,
   input  logic                          cfg_half,
   input  logic                          req_valid,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic                          req_write,
   input  logic                          req_burst,
   input  logic                          req_inhibit,
   input  logic                          req_itm,
   input  logic                          req_cwf,
   output logic                          req_done,
   output logic                          bus_req,
   input  logic                          bus_grant,
   output logic                          start_strobe,
   output logic                          abus_busy,
   input  logic                          addr_ack,
   output logic                          a_oe,
   output logic [ADDR_W-1:0]             a_addr,
   output logic                          a_write,
   output logic                          a_burst,
   output logic                          a_inval,
   input  logic                          dbus_grant,
   input  logic                          dbus_busy_in,
   output logic                          dbus_busy,
   input  logic                          xfer_ack,
   output logic [ADDR_W-1:0]             beat_addr,
   output logic [$clog2(LONG_BEATS)-1:0] beat_word,
   input  logic [DATA_W-1:0]             wr_data,
   output logic                          d_oe,
   output logic [DATA_W-1:0]             d_out,
   output logic                          rd_strobe,
   output logic [$clog2(LONG_BEATS)-1:0] rd_word
);
   localparam int BYTE_LG = $clog2(DATA_W / 8);
   localparam int WORD_LG = $clog2(LONG_BEATS);

   generate
      if (DATA_W % 8 != 0 || (1 << BYTE_LG) != DATA_W / 8)
         $error("DATA_W must be a power-of-two number of bytes");
      if ((1 << WORD_LG) != LONG_BEATS || SHORT_BEATS > LONG_BEATS || SHORT_BEATS < 1)
         $error("beat counts must be powers of two with SHORT_BEATS <= LONG_BEATS");
      if ((1 << $clog2(SHORT_BEATS)) != SHORT_BEATS)
         $error("SHORT_BEATS must be a power of two");
      if (ADDR_W <= BYTE_LG + WORD_LG)
         $error("ADDR_W too small for the line");
   endgenerate

   bm_state_e          state;
   logic               accept, start_q, beat_adv, beat_clr, last_beat;
   logic [ADDR_W-1:0]  r_addr;
   logic               r_write, r_burst, r_itm, r_cwf, r_long, r_half;
   logic [WORD_LG-1:0] beat_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_addr  <= '0;
         r_write <= 1'b0;
         r_burst <= 1'b0;
         r_itm   <= 1'b0;
         r_cwf   <= 1'b0;
         r_long  <= 1'b0;
         r_half  <= 1'b0;
      end else if (accept) begin
         r_addr  <= req_addr;
         r_write <= req_write;
         r_burst <= req_burst && !req_inhibit;
         r_itm   <= req_itm;
         r_cwf   <= req_cwf;
         r_long  <= cfg_line64;
         r_half  <= cfg_half;
      end
   end

   assign beat_mask = !r_burst ? '0 :
                      r_long   ? WORD_LG'(LONG_BEATS - 1) : WORD_LG'(SHORT_BEATS - 1);

   bm_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .bus_grant    (bus_grant),
      .addr_ack     (addr_ack),
      .dbus_grant   (dbus_grant),
      .dbus_busy_in (dbus_busy_in),
      .xfer_ack     (xfer_ack),
      .last_beat    (last_beat),
      .state        (state),
      .accept       (accept),
      .start_q      (start_q),
      .beat_adv     (beat_adv),
      .beat_clr     (beat_clr)
   );

   bm_beat_gen #(.ADDR_W(ADDR_W), .BYTE_LG(BYTE_LG), .WORD_LG(WORD_LG)) u_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (beat_clr),
      .adv       (beat_adv),
      .base      (r_addr),
      .mask      (beat_mask),
      .cwf       (r_cwf),
      .beat_addr (beat_addr),
      .word      (beat_word),
      .last      (last_beat)
   );

   bm_ack_align #(.WORD_LG(WORD_LG)) u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .half      (r_half),
      .ack_rd    (beat_adv && !r_write),
      .word      (beat_word),
      .rd_strobe (rd_strobe),
      .rd_word   (rd_word)
   );

   assign bus_req      = (state == ST_ARB);
   assign start_strobe = start_q;
   assign a_oe         = (state == ST_ADDR);
   assign abus_busy    = a_oe;
   assign a_addr       = a_oe ? r_addr : '0;
   assign a_write      = a_oe && r_write;
   assign a_burst      = a_oe && r_burst;
   assign a_inval      = a_oe && r_burst && r_itm && !r_write;
   assign dbus_busy    = (state == ST_DATA);
   assign d_oe         = dbus_busy && r_write;
   assign d_out        = d_oe ? wr_data : '0;
   assign req_done     = (state == ST_DONE);
endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_half,
   input logic              bus_req,
   input logic              bus_grant,
   input logic              start_strobe,
   input logic              a_oe,
   input logic              addr_ack,
   input logic              dbus_grant,
   input logic              dbus_busy_in,
   input logic              dbus_busy,
   input logic              xfer_ack,
   input logic [ADDR_W-1:0] beat_addr,
   input logic              d_oe,
   input logic              rd_strobe,
   input logic              req_done
);
   AST_STB_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      start_strobe |-> (!bus_req && a_oe)); // R4
   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_strobe |=> !start_strobe); // R4
   AST_STB_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_strobe) |-> $past(bus_grant && bus_req)); // R4
   AST_ATTR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(a_oe) |-> $past(addr_ack)); // R5
   AST_DATA_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbus_busy) |-> $past(dbus_grant && !dbus_busy_in)); // R6
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_busy && !xfer_ack) |=> $stable(beat_addr)); // R7
   AST_HALF_SAME_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_half && dbus_busy && xfer_ack && !d_oe) |-> rd_strobe); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done); // R11
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> (!a_oe && !dbus_busy && !bus_req)); // R11
endmodule

bind burst_bus_master bm_checker #(.ADDR_W(ADDR_W)) u_bm_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_half     (cfg_half),
   .bus_req      (bus_req),
   .bus_grant    (bus_grant),
   .start_strobe (start_strobe),
   .a_oe         (a_oe),
   .addr_ack     (addr_ack),
   .dbus_grant   (dbus_grant),
   .dbus_busy_in (dbus_busy_in),
   .dbus_busy    (dbus_busy),
   .xfer_ack     (xfer_ack),
   .beat_addr    (beat_addr),
   .d_oe         (d_oe),
   .rd_strobe    (rd_strobe),
   .req_done     (req_done)
);

// File: tb/tb_burst_bus_master.sv
`timescale 1ns/1ps
module tb_burst_bus_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_line64 = 0, cfg_half = 0;
   logic        req_valid = 0, req_write = 0, req_burst = 0, req_inhibit = 0, req_itm = 0, req_cwf = 0;
   logic [31:0] req_addr = '0;
   logic        bus_grant = 0, addr_ack = 0, dbus_grant = 0, dbus_busy_in = 0, xfer_ack = 0;
   logic        req_done, bus_req, start_strobe, abus_busy, a_oe, a_write, a_burst, a_inval;
   logic        dbus_busy, d_oe, rd_strobe;
   logic [31:0] a_addr, beat_addr;
   logic [2:0]  beat_word, rd_word;
   logic [63:0] wr_data, d_out;

   int nchk = 0, nfail = 0;
   bit prev_rd = 0;
   logic [2:0] prev_word = '0;

   typedef struct { logic [2:0] word; logic [31:0] addr; } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   assign wr_data = 64'hFEED_FACE_0000_0000 + {61'd0, beat_word};

   burst_bus_master dut (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // scoreboard monitor: beat addresses, write data, read strobe timing
   always @(negedge clk) begin
      if (rst_n) begin
         bit cur_rd;
         if (dbus_busy) begin
            if (sb.size() == 0) chk("R1 extra beat", 1, 0);
            else begin
               chk("R2/R7 beat_addr", beat_addr, sb[0].addr);
               chk("R2/R7 beat_word", beat_word, sb[0].word);
               if (xfer_ack) begin
                  if (d_oe) chk("R10 d_out", d_out, 64'hFEED_FACE_0000_0000 + sb[0].word);
                  void'(sb.pop_front());
               end
            end
         end
         cur_rd = dbus_busy && xfer_ack && !d_oe;
         if (cfg_half ? cur_rd : prev_rd) begin
            chk("R8 rd_strobe", rd_strobe, 1);
            chk("R8 rd_word", rd_word, cfg_half ? beat_word : prev_word);
         end else if (rd_strobe) chk("R8 stray rd_strobe", rd_strobe, 0);
         prev_rd   = cur_rd;
         prev_word = beat_word;
      end
   end

   task automatic run(input logic [31:0] addr, input bit wr, input bit bst, input bit inh,
                      input bit itm, input bit cwf, input bit lng, input bit hlf, input int wbeat);
      int n, m, s;
      n = (inh || !bst) ? 1 : (lng ? 8 : 4);
      m = n - 1;
      s = cwf ? ((addr >> 3) & m) : 0;
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.word = 3'((s + i) & m);
         e.addr = (addr & ~(32'(m) << 3) & ~32'h7) | (32'(e.word) << 3);
         sb.push_back(e);
      end
      cfg_line64 = lng; cfg_half = hlf;
      req_addr = addr; req_write = wr; req_burst = bst; req_inhibit = inh;
      req_itm = itm; req_cwf = cwf; req_valid = 1;
      step();
      req_valid = 0;
      @(negedge clk);
      chk("R4 bus_req held", bus_req, 1);
      step(); step();
      @(negedge clk);
      chk("R4 bus_req waits for grant", bus_req, 1);
      chk("R4 no early strobe", start_strobe, 0);
      bus_grant = 1;
      step();
      bus_grant = 0;
      @(negedge clk);
      chk("R4 strobe", start_strobe, 1);
      chk("R4 bus_req dropped", bus_req, 0);
      chk("R4 abus_busy", abus_busy, 1);
      chk("R4 a_addr", a_addr, addr);
      chk("R4 a_write", a_write, wr);
      chk("R3 a_burst", a_burst, bst && !inh);
      chk("R9 a_inval", a_inval, !wr && bst && !inh && itm);
      step();
      @(negedge clk);
      chk("R4 strobe one clock", start_strobe, 0);
      chk("R5 a_oe held", a_oe, 1);
      addr_ack = 1;
      step();
      addr_ack = 0;
      @(negedge clk);
      chk("R5 a_oe released", a_oe, 0);
      dbus_grant = 1; dbus_busy_in = 1;
      step();
      @(negedge clk);
      chk("R6 no tenure while busy", dbus_busy, 0);
      dbus_busy_in = 0;
      step();
      dbus_grant = 0;
      @(negedge clk);
      chk("R6 tenure", dbus_busy, 1);
      chk("R10 d_oe", d_oe, wr);
      for (int i = 0; i < n; i++) begin
         if (i == wbeat) begin
            xfer_ack = 0;
            step(); step();
         end
         xfer_ack = 1;
         step();
      end
      xfer_ack = 0;
      @(negedge clk);
      chk("R11 done", req_done, 1);
      chk("R11 data released", dbus_busy, 0);
      chk("R11 addr released", a_oe, 0);
      chk("R1 beat count", sb.size(), 0);
      step();
      @(negedge clk);
      chk("R11 done single", req_done, 0);
      step();
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL R11 watchdog act=hung exp=done");
      finish_up();
   end

   initial begin
      repeat (3) step();
      @(negedge clk);
      chk("R11 reset bus_req", bus_req, 0);
      chk("R11 reset a_oe", a_oe, 0);
      chk("R11 reset dbus_busy", dbus_busy, 0);
      chk("R11 reset done", req_done, 0);
      rst_n = 1;
      step();
      // R1 R2 zero-word-first 4-beat fill, full speed
      run(32'h1000_0028, 0, 1, 0, 0, 0, 0, 0, 2);
      // R2 R9 critical-word-first 4 beats, intent-to-modify
      run(32'h2000_0030, 0, 1, 0, 1, 1, 0, 0, 0);
      // R1 R8 critical-word-first 8 beats, half speed, waits
      run(32'h3000_0068, 0, 1, 0, 0, 1, 1, 1, 3);
      // R3 inhibited: single beat, no invalidate
      run(32'h4000_007C, 0, 1, 1, 1, 1, 1, 0, 0);
      // R10 write critical-word-first 8 beats full speed, wait on beat 5
      run(32'h5000_0050, 1, 1, 0, 1, 1, 1, 0, 5);
      // R10 write zero-word-first 4 beats half speed
      run(32'h6000_0018, 1, 1, 0, 0, 0, 0, 1, 1);
      // R3 plain single-beat read, half speed
      run(32'h7000_0044, 0, 0, 0, 0, 1, 0, 1, 0);
      finish_up();
   end
endmodule